// File: doc/BRIEF.md
# Signed Fractional Multiply-Accumulate Unit

This unit multiplies signed two's-complement operands. Each operand is read either as a fraction in [-1, 1) or as a plain signed integer. In narrow mode it takes the low byte of each operand and returns a 16-bit product, sign-extended onto the result bus. In wide mode it multiplies two 16-bit operands and adds the 32-bit product into a running 32-bit accumulator. It then returns the new accumulator value together with a signed-overflow flag.

Fractional alignment is a one-bit left shift of the integer product, with a zero shifted into the least significant bit. The single product that cannot be represented is (-1)·(-1). It therefore wraps to the bit pattern of -1, and this holds for both widths. Operations enter through a valid/ready handshake and pass through a product register and then an accumulate/output register. Results leave through a second valid/ready handshake in the order the operations were accepted. A clear input empties the accumulator.

Top module: `frac_mac`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the accumulator holds zero. The first wide operation after reset therefore reports its own product.
- R2: Narrow fractional mode (in_wide=0, in_int=0) reads only bits [7:0] of each operand. It returns the 16-bit product shifted left by one and sign-extended to 32 bits. For example, 0xB0 (-0.625) times 0x40 (0.5) gives 0xFFFFD800.
- R3: In narrow fractional mode, 0x80 times 0x80 returns 0xFFFF8000 (-1), not +1.
- R4: Wide fractional mode (in_wide=1, in_int=0) adds the 32-bit product, shifted left by one, into the accumulator modulo 2^32. out_data is the new accumulator value.
- R5: In wide fractional mode, 0x8000 times 0x8000 adds 0x80000000 (-1) to the accumulator.
- R6: Integer mode (in_int=1) applies no shift, at either width.
- R7: out_ovf is 1 when the signed 32-bit addition of a wide operation overflows. It is always 0 for narrow operations.
- R8: Narrow operations leave the accumulator unchanged.
- R9: acc_clear zeroes the accumulator at the next clock edge. If a wide operation reaches the accumulator at that same edge, the clear wins: that operation reports 0 with out_ovf 0, and the accumulator stays 0.
- R10: While out_valid=1 and out_ready=0, out_data and out_ovf hold steady. Results emerge in acceptance order and none is lost. With out_ready held high and the pipe empty, an operation accepted at edge k is presented after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_wide | input | 1 | 1 = 16x16 accumulate, 0 = 8x8 multiply |
| in_int | input | 1 | 1 = signed integer, 0 = fractional |
| in_a | input | WIDE_W | First operand (low NARROW_W bits in narrow mode) |
| in_b | input | WIDE_W | Second operand (low NARROW_W bits in narrow mode) |
| acc_clear | input | 1 | Zero the accumulator at the next edge |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | ACC_W | Product (narrow) or new accumulator value (wide) |
| out_ovf | output | 1 | Signed overflow of the accumulate |

## Verification
The hold assertions assume a standard source. Once in_valid rises with an operation, that operation stays unchanged until in_ready accepts it. The bench driver holds every operation until it sees in_ready, and out_ready is randomised only on the consumer side.

The clear-priority case assumes acc_clear is raised only when the bench knows which edge the accumulate falls on. Clears are therefore issued only after the pipe has drained and with out_ready held high. The random phase never raises acc_clear.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef struct packed {
    logic wide;
    logic int_mode;
  } fmac_ctl_t;
endpackage

// File: rtl/fmac_mul_stage.sv
module fmac_mul_stage
  import fmac_pkg::*;
#(
  parameter int NW = 8,
  parameter int WW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  fmac_ctl_t     in_ctl,
  input  logic [WW-1:0] in_a,
  input  logic [WW-1:0] in_b,
  output logic          s_valid,
  input  logic          s_ready,
  output fmac_ctl_t     s_ctl,
  output logic [AW-1:0] s_prod
);
  localparam int NP = 2 * NW;
  localparam int WP = 2 * WW;
  localparam logic [NW-1:0] NMIN = {1'b1, {(NW-1){1'b0}}};
  localparam logic [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};
  localparam logic signed [NP-1:0] NMIN_P = {1'b1, {(NP-1){1'b0}}};
  localparam logic signed [WP-1:0] WMIN_P = {1'b1, {(WP-1){1'b0}}};

  logic signed [NP-1:0] pn, pn_al;
  logic signed [WP-1:0] pw, pw_al;
  logic [AW-1:0]        prod_d;

  always_comb begin
    pn     = NP'($signed(in_a[NW-1:0])) * NP'($signed(in_b[NW-1:0]));
    pw     = WP'($signed(in_a)) * WP'($signed(in_b));
    pn_al  = in_ctl.int_mode ? pn : (pn <<< 1);
    pw_al  = in_ctl.int_mode ? pw : (pw <<< 1);
    prod_d = in_ctl.wide ? AW'(pw_al) : AW'(pn_al);
  end

  assign in_ready = !s_valid || s_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_ctl   <= '0;
      s_prod  <= '0;
    end else if (in_ready) begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_ctl  <= in_ctl;
        s_prod <= prod_d;
      end
    end
  end

  // R3
  narrow_min_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_ctl.wide && !in_ctl.int_mode &&
     in_a[NW-1:0] == NMIN && in_b[NW-1:0] == NMIN) |=> (s_prod == AW'(NMIN_P)));

  // R5
  wide_min_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_ctl.wide && !in_ctl.int_mode &&
     in_a == WMIN && in_b == WMIN) |=> (s_prod == AW'(WMIN_P)));

  // R10
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_prod) && $stable(s_ctl)));
endmodule

// File: rtl/fmac_acc_stage.sv
module fmac_acc_stage
  import fmac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  fmac_ctl_t     s_ctl,
  input  logic [AW-1:0] s_prod,
  input  logic          acc_clear,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data,
  output logic          out_ovf
);
  logic [AW-1:0] acc, sum;
  logic          add_ovf, load;

  assign s_ready = !out_valid || out_ready;
  assign load    = s_valid && s_ready;

  always_comb begin
    sum     = acc + s_prod;
    add_ovf = (acc[AW-1] == s_prod[AW-1]) && (sum[AW-1] != acc[AW-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      if (load)
        out_valid <= 1'b1;
      else if (out_ready)
        out_valid <= 1'b0;

      if (load && s_ctl.wide) begin
        if (acc_clear) begin
          acc      <= '0;
          out_data <= '0;
          out_ovf  <= 1'b0;
        end else begin
          acc      <= sum;
          out_data <= sum;
          out_ovf  <= add_ovf;
        end
      end else begin
        if (acc_clear)
          acc <= '0;
        if (load) begin
          out_data <= s_prod;
          out_ovf  <= 1'b0;
        end
      end
    end
  end

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    acc_clear |=> (acc == '0));

  // R8
  narrow_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !s_ctl.wide && !acc_clear) |=> $stable(acc));

  // R7
  narrow_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !s_ctl.wide) |=> !out_ovf);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf)));
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import fmac_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16,
  parameter int ACC_W    = 2 * WIDE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_wide,
  input  logic              in_int,
  input  logic [WIDE_W-1:0] in_a,
  input  logic [WIDE_W-1:0] in_b,
  input  logic              acc_clear,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data,
  output logic              out_ovf
);
  fmac_ctl_t        in_ctl, s_ctl;
  logic             s_valid, s_ready;
  logic [ACC_W-1:0] s_prod;

  assign in_ctl.wide     = in_wide;
  assign in_ctl.int_mode = in_int;

  fmac_mul_stage #(.NW(NARROW_W), .WW(WIDE_W), .AW(ACC_W)) mul_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_ctl(in_ctl),
    .in_a(in_a), .in_b(in_b),
    .s_valid(s_valid), .s_ready(s_ready), .s_ctl(s_ctl), .s_prod(s_prod)
  );

  fmac_acc_stage #(.AW(ACC_W)) acc_i (
    .clk(clk), .rst(rst),
    .s_valid(s_valid), .s_ready(s_ready), .s_ctl(s_ctl), .s_prod(s_prod),
    .acc_clear(acc_clear),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ovf(out_ovf)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));
endmodule

// File: tb/frac_mac_tb_top.sv
module frac_mac_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst = 1'b1, in_valid = 1'b0, in_wide = 1'b0, in_int = 1'b0;
  logic [15:0] in_a = '0, in_b = '0;
  logic        acc_clear = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, out_ovf;
  logic [31:0] out_data;

  frac_mac dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_wide(in_wide), .in_int(in_int), .in_a(in_a), .in_b(in_b),
    .acc_clear(acc_clear), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ovf(out_ovf)
  );

  int          checks = 0, fails = 0;
  bit          bp_en = 1'b0, finished = 1'b0;
  logic [31:0] macc = '0;
  logic [31:0] qr[$];
  bit          qo[$];
  int          qt[$];

  function automatic string tname(int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, int t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tname(t), what, act, exp);
    end
  endtask

  // Reference model on wide integers
  task automatic model(bit w, bit im, logic [15:0] a, logic [15:0] b, bit clr,
                       output logic [31:0] r, output bit o, output int tag);
    longint p, s;
    logic [15:0] r16;
    if (!w) begin
      p = longint'($signed(a[7:0])) * longint'($signed(b[7:0]));
      if (!im) p = p * 2;
      r16 = p[15:0];
      r   = {{16{r16[15]}}, r16};
      o   = 1'b0;
      tag = im ? 6 : ((a[7:0] == 8'h80 && b[7:0] == 8'h80) ? 3 : 2);
    end else begin
      p = longint'($signed(a)) * longint'($signed(b));
      if (!im) p = p * 2;
      s = longint'($signed(macc)) + longint'($signed(p[31:0]));
      o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      r = s[31:0];
      tag = im ? 6 : (o ? 7 : ((a == 16'h8000 && b == 16'h8000) ? 5 : 4));
      if (clr) begin
        r = '0; o = 1'b0;
      end
      macc = r;
    end
  endtask

  task automatic send(bit w, bit im, logic [15:0] a, logic [15:0] b, int ovt, bit clr);
    logic [31:0] r; bit o; int tag;
    @(negedge clk);
    in_valid = 1'b1; in_wide = w; in_int = im; in_a = a; in_b = b;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    model(w, im, a, b, clr, r, o, tag);
    if (ovt != 0) tag = ovt;
    qr.push_back(r); qo.push_back(o); qt.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (clr) begin
      acc_clear = 1'b1;
      @(posedge clk); #1;
      acc_clear = 1'b0;
    end
  endtask

  task automatic drain();
    while (qr.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_alone();
    drain();
    @(negedge clk); acc_clear = 1'b1;
    @(negedge clk); acc_clear = 1'b0;
    macc = '0;
  endtask

  // Consumer / checker
  initial begin
    logic [31:0] held, r;
    bit hold, o;
    int t;
    hold = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = bp_en ? ($urandom % 4 != 0) : 1'b1;
      #1;
      if (rst) continue;
      if (hold) begin
        check(out_valid && out_data == held, 10, "held result", out_data, held);
        hold = 1'b0;
      end
      if (out_valid) begin
        if (out_ready) begin
          if (qr.size() == 0) check(1'b0, 10, "unexpected result", out_data, '0);
          else begin
            r = qr.pop_front(); o = qo.pop_front(); t = qt.pop_front();
            check(out_data == r, t, "data", out_data, r);
            check(out_ovf == o, t, "ovf", {31'd0, out_ovf}, {31'd0, o});
          end
        end else begin
          held = out_data; hold = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #2;
    // R1 idle after reset
    check(!out_valid, 1, "out_valid after reset", {31'd0, out_valid}, '0);
    check(in_ready, 1, "in_ready after reset", {31'd0, in_ready}, 32'd1);
    // R1 accumulator starts at zero: 0x62C0 (0.771484375) * 0.5
    send(1, 0, 16'h62C0, 16'h4000, 1, 0);
    // R2 0xB0 = -0.625 times 0.5, junk in upper byte
    send(0, 0, 16'hA5B0, 16'h3C40, 0, 0);
    drain();
    check(macc == 32'h3160_0000, 1, "model sanity", macc, 32'h3160_0000);
    // R3 narrow -1 * -1
    send(0, 0, 16'h1280, 16'hFF80, 0, 0);
    // R5 wide -1 * -1
    send(1, 0, 16'h8000, 16'h8000, 0, 0);
    // R6 integer mode both widths
    send(0, 1, 16'h00B0, 16'h0040, 0, 0);
    send(1, 1, 16'h8000, 16'h8000, 0, 0);
    send(1, 1, 16'h1234, 16'hFEDC, 0, 0);
    // R7 positive overflow
    clear_alone();
    send(1, 0, 16'h7FFF, 16'h7FFF, 0, 0);
    send(1, 0, 16'h7FFF, 16'h7FFF, 0, 0);
    // R8 narrow op keeps accumulator
    send(0, 0, 16'h007F, 16'h0081, 0, 0);
    send(1, 0, 16'h0000, 16'h0000, 8, 0);
    // R9 clear alone, then clear racing an accumulate
    clear_alone();
    send(1, 0, 16'h0000, 16'h0000, 9, 0);
    send(1, 0, 16'h3000, 16'h1000, 0, 0);
    drain();
    send(1, 0, 16'h4000, 16'h4000, 9, 1);
    send(1, 0, 16'h2000, 16'h4000, 9, 0);
    // R10 latency with empty pipe
    drain();
    send(1, 0, 16'h0100, 16'h0100, 0, 0);
    @(negedge clk); #2;
    check(!out_valid, 10, "not yet valid", {31'd0, out_valid}, '0);
    @(negedge clk); #2;
    check(out_valid, 10, "valid after two edges", {31'd0, out_valid}, 32'd1);
    drain();
    // Random phase with backpressure (R2 R4 R6 R10)
    bp_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      bit w, im;
      w  = $urandom % 2;
      im = ($urandom % 4 == 0);
      a  = $urandom; b = $urandom;
      if ($urandom % 8 == 0) begin a[7:0] = 8'h80; a[15:8] = w ? 8'h80 : a[15:8]; end
      if ($urandom % 8 == 0) begin b[7:0] = 8'h80; b[15:8] = w ? 8'h80 : b[15:8]; end
      send(w, im, a, b, 0, 0);
    end
    bp_en = 1'b0;
    drain();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule